// File: doc/BRIEF.md
# Pixel Readout Buffer with Token-Passed Serial Output

This block sits in the periphery of a pixel readout chip. On the column side it stands between the double-column hit stores and the chip's serial output. On the chip side it stands between that output and the readout token chain. A round-robin sequencer moves one hit record per core cycle from any double column that offers one into a local readout buffer. It does this without waiting for the external token, so the column stores are freed early. When the buffer is full the sequencer holds off the columns and counts every such cycle in a saturating lost-hit counter.

A token controller waits for the external readout token. When the token arrives, the controller takes a snapshot of how many records the buffer holds. It then sends a fixed header, those records and a trailer, and hands the token to the next chip with a one-cycle pulse. If the buffer was empty it sends only the header. Each record is carried as 4-bit groups. A serializer clocked at four times the core clock shifts out one group per core cycle and flags the first bit of each group on a sync line.

Top module: `pix_rdo_top`

## Requirements
- R1: After reset the token output, the sync line, the serial data line, every column acknowledge and the lost-hit counter are all zero.
- R2: The sequencer grants at most one column per core cycle, shown by a one-hot `col_ack`, and only to a column whose valid is high. The search starts at the column after the last one granted, wraps after column NCOL-1 and starts at column 0 after reset.
- R3: The readout buffer holds DEPTH records. While it is full no column is acknowledged.
- R4: Each core cycle in which some column is valid and the buffer is full adds one to `lost_cnt`. A cycle with a grant leaves it unchanged.
- R5: `lost_cnt` saturates at its all-ones value.
- R6: A token pulse that finds the buffer empty produces exactly the header nibbles 0xA then 0x6 and nothing else. A single-cycle `token_out` pulse follows.
- R7: A token pulse that finds N>0 records produces the following, then one `token_out` pulse:
  - the header nibbles 0xA and 0x6;
  - the N records in the order they were acknowledged;
  - the trailer nibble 0x9.

  Each record is sent as 24 bits {1'b0, 23-bit record}, where the record is the column's `col_data` slice [i*23 +: 23], in six nibbles with the most significant nibble first.
- R8: The serial line carries one nibble per core cycle, most significant bit first. `ser_sync` is high only during the first bit of a valid nibble, and `ser_data` is 0 outside valid nibbles.
- R9: Records acknowledged in or after the cycle in which a token is accepted are not part of that frame. They are sent by the next token.
- R10: A token pulse that arrives while a frame is in progress is ignored. It yields no extra frame and no extra `token_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| clk_fast | input | 1 | Serializer clock, four times the core clock, rising edges aligned |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| col_valid | input | NCOL | One bit per double column: a record is waiting |
| col_data | input | NCOL*(ADDR_W+PH_W) | Records, column i at bits [i*23 +: 23] by default |
| col_ack | output | NCOL | One-hot grant; the granted record is copied at this clock edge |
| token_in | input | 1 | Readout token from the previous chip (one-cycle pulse) |
| token_out | output | 1 | Token passed on after the frame (one-cycle pulse) |
| lost_cnt | output | LOST_W | Saturating count of full-buffer stall cycles |
| ser_data | output | 1 | Serial bit stream, clk_fast domain |
| ser_sync | output | 1 | High on the first bit of each valid nibble |

## Verification
The bench builds the block with 26 columns and an 8-entry buffer, so keeping every column valid fills the buffer within eight cycles. That makes the full-buffer stall and the round-robin wrap-around easy to reach. The lost-hit counter is narrowed to 4 bits, so saturation at 15 arrives after a short stall. The random phase, with narrow token spacing, mixes frames that find an empty buffer, frames that find a full one, and records that arrive during a drain.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
   localparam int NIB_W = 4;

   typedef enum logic [2:0] {
      TS_IDLE,
      TS_HDR,
      TS_LOAD,
      TS_SEND,
      TS_TRAIL,
      TS_PASS
   } tok_state_t;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/rdo_col_seq.sv
module rdo_col_seq #(
   parameter int NCOL   = 26,
   parameter int REC_W  = 23,
   parameter int LOST_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NCOL-1:0]         col_valid,
   input  logic [NCOL*REC_W-1:0]   col_data,
   input  logic                    buf_full,
   output logic [NCOL-1:0]         col_ack,
   output logic                    wr_en,
   output logic [REC_W-1:0]        wr_data,
   output logic [LOST_W-1:0]       lost_cnt
);
   localparam int PW = (NCOL > 1) ? $clog2(NCOL) : 1;

   logic [REC_W-1:0] col_rec [NCOL];
   logic [PW-1:0]    ptr_q;
   logic [PW-1:0]    sel;
   logic             found;
   logic             grant;
   logic [LOST_W-1:0] lost_q;

   for (genvar g = 0; g < NCOL; g++) begin : g_slice
      assign col_rec[g] = col_data[g*REC_W +: REC_W];
   end

   always_comb begin
      found = 1'b0;
      sel   = '0;
      for (int k = 0; k < NCOL; k++) begin
         int j;
         j = int'(ptr_q) + k;
         if (j >= NCOL) j = j - NCOL;
         if (!found && col_valid[j]) begin
            found = 1'b1;
            sel   = PW'(j);
         end
      end
   end

   assign grant   = found && !buf_full;
   assign col_ack = grant ? (NCOL'(1) << sel) : '0;
   assign wr_en   = grant;
   assign wr_data = col_rec[sel];
   assign lost_cnt = lost_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         lost_q <= '0;
      end else begin
         if (grant) begin
            ptr_q <= (int'(sel) == NCOL-1) ? '0 : sel + PW'(1);
         end
         if ((|col_valid) && buf_full && (lost_q != '1)) begin
            lost_q <= lost_q + LOST_W'(1);
         end
      end
   end
endmodule

// File: rtl/rdo_fifo.sv
module rdo_fifo #(
   parameter int W     = 23,
   parameter int DEPTH = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [W-1:0]  wr_data,
   input  logic          rd_en,
   output logic [W-1:0]  rd_data,
   output logic [CW-1:0] count,
   output logic          full
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [CW-1:0] cnt_q;
   logic          do_wr, do_rd;

   assign full    = (cnt_q == CW'(DEPTH));
   assign do_wr   = wr_en && !full;
   assign do_rd   = rd_en && (cnt_q != '0);
   assign rd_data = mem[rp_q];
   assign count   = cnt_q;

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp_q] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_wr) wp_q <= wp_q + AW'(1);
         if (do_rd) rp_q <= rp_q + AW'(1);
         case ({do_wr, do_rd})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/rdo_token_ctl.sv
module rdo_token_ctl
   import rdo_pkg::*;
#(
   parameter int REC_W    = 23,
   parameter int CNT_W    = 4,
   parameter int HDR_NIBS = 2,
   parameter logic [4*HDR_NIBS-1:0] HDR_PATTERN = 8'hA6,
   parameter logic [3:0] TRL_NIB = 4'h9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             token_in,
   input  logic [CNT_W-1:0] buf_count,
   input  logic [REC_W-1:0] buf_head,
   output logic             pop,
   output logic             nib_v,
   output logic [3:0]       nib,
   output logic             token_out
);
   localparam int NPR   = (REC_W + NIB_W - 1) / NIB_W;
   localparam int PAD_W = NPR * NIB_W;
   localparam int MAXN  = max2(HDR_NIBS, NPR);
   localparam int IW    = (MAXN > 1) ? $clog2(MAXN) : 1;

   tok_state_t       st_q;
   logic [IW-1:0]    idx_q;
   logic [CNT_W-1:0] remain_q;
   logic [PAD_W-1:0] sh_q;
   logic             tok_q;

   always_comb begin
      nib_v = 1'b0;
      nib   = '0;
      pop   = 1'b0;
      case (st_q)
         TS_HDR: begin
            nib_v = 1'b1;
            nib   = HDR_PATTERN[NIB_W*(HDR_NIBS-1-int'(idx_q)) +: NIB_W];
         end
         TS_LOAD:  pop = 1'b1;
         TS_SEND: begin
            nib_v = 1'b1;
            nib   = sh_q[PAD_W-1 -: NIB_W];
         end
         TS_TRAIL: begin
            nib_v = 1'b1;
            nib   = TRL_NIB;
         end
         default: ;
      endcase
   end

   assign token_out = tok_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= TS_IDLE;
         idx_q    <= '0;
         remain_q <= '0;
         sh_q     <= '0;
         tok_q    <= 1'b0;
      end else begin
         tok_q <= (st_q == TS_PASS);
         case (st_q)
            TS_IDLE: if (token_in) begin
               remain_q <= buf_count;
               idx_q    <= '0;
               st_q     <= TS_HDR;
            end
            TS_HDR: begin
               if (idx_q == IW'(HDR_NIBS-1)) begin
                  idx_q <= '0;
                  st_q  <= (remain_q == '0) ? TS_PASS : TS_LOAD;
               end else begin
                  idx_q <= idx_q + IW'(1);
               end
            end
            TS_LOAD: begin
               sh_q     <= PAD_W'(buf_head);
               remain_q <= remain_q - CNT_W'(1);
               idx_q    <= '0;
               st_q     <= TS_SEND;
            end
            TS_SEND: begin
               sh_q <= sh_q << NIB_W;
               if (idx_q == IW'(NPR-1)) begin
                  idx_q <= '0;
                  st_q  <= (remain_q == '0) ? TS_TRAIL : TS_LOAD;
               end else begin
                  idx_q <= idx_q + IW'(1);
               end
            end
            TS_TRAIL: st_q <= TS_PASS;
            TS_PASS:  st_q <= TS_IDLE;
            default:  st_q <= TS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rdo_serializer.sv
module rdo_serializer #(
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic       clk,
   input  logic       clk_fast,
   input  logic       rst_n,
   input  logic       nib_v,
   input  logic [3:0] nib,
   output logic       ser_data,
   output logic       ser_sync
);
   logic [3:0] hold_q;
   logic       hv_q;
   logic       tgl_q;
   logic       tgl_d;
   logic [3:0] sh_q;
   logic [3:0] sh_next;
   logic       out_bit;
   logic       val_q;
   logic       first_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
         hv_q   <= 1'b0;
         tgl_q  <= 1'b0;
      end else begin
         hold_q <= nib;
         hv_q   <= nib_v;
         tgl_q  <= ~tgl_q;
      end
   end

   if (MSB_FIRST) begin : g_msb
      assign sh_next = {sh_q[2:0], 1'b0};
      assign out_bit = sh_q[3];
   end else begin : g_lsb
      assign sh_next = {1'b0, sh_q[3:1]};
      assign out_bit = sh_q[0];
   end

   always_ff @(posedge clk_fast) begin
      if (!rst_n) begin
         tgl_d   <= 1'b0;
         sh_q    <= '0;
         val_q   <= 1'b0;
         first_q <= 1'b0;
      end else begin
         tgl_d <= tgl_q;
         if (tgl_q != tgl_d) begin
            sh_q    <= hold_q;
            val_q   <= hv_q;
            first_q <= 1'b1;
         end else begin
            sh_q    <= sh_next;
            first_q <= 1'b0;
         end
      end
   end

   assign ser_data = val_q & out_bit;
   assign ser_sync = val_q & first_q;
endmodule

// File: rtl/pix_rdo_top.sv
module pix_rdo_top #(
   parameter int NCOL      = 26,
   parameter int ADDR_W    = 15,
   parameter int PH_W      = 8,
   parameter int DEPTH     = 8,
   parameter int LOST_W    = 8,
   parameter int HDR_NIBS  = 2,
   parameter logic [4*HDR_NIBS-1:0] HDR_PATTERN = 8'hA6,
   parameter logic [3:0] TRL_NIB = 4'h9,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic                              clk,
   input  logic                              clk_fast,
   input  logic                              rst_n,
   input  logic [NCOL-1:0]                   col_valid,
   input  logic [NCOL*(ADDR_W+PH_W)-1:0]     col_data,
   output logic [NCOL-1:0]                   col_ack,
   input  logic                              token_in,
   output logic                              token_out,
   output logic [LOST_W-1:0]                 lost_cnt,
   output logic                              ser_data,
   output logic                              ser_sync
);
   localparam int REC_W = ADDR_W + PH_W;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (NCOL < 2) begin : g_bad_ncol
      $error("NCOL must be at least 2");
   end
   if (HDR_NIBS < 1 || LOST_W < 1) begin : g_bad_misc
      $error("HDR_NIBS and LOST_W must be positive");
   end

   logic             wr_en;
   logic [REC_W-1:0] wr_data;
   logic             buf_full;
   logic [CNT_W-1:0] buf_count;
   logic [REC_W-1:0] buf_head;
   logic             pop;
   logic             nib_v;
   logic [3:0]       nib;

   rdo_col_seq #(.NCOL(NCOL), .REC_W(REC_W), .LOST_W(LOST_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .col_valid(col_valid), .col_data(col_data),
      .buf_full(buf_full), .col_ack(col_ack), .wr_en(wr_en),
      .wr_data(wr_data), .lost_cnt(lost_cnt)
   );

   rdo_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(pop), .rd_data(buf_head), .count(buf_count), .full(buf_full)
   );

   rdo_token_ctl #(
      .REC_W(REC_W), .CNT_W(CNT_W), .HDR_NIBS(HDR_NIBS),
      .HDR_PATTERN(HDR_PATTERN), .TRL_NIB(TRL_NIB)
   ) u_tok (
      .clk(clk), .rst_n(rst_n), .token_in(token_in), .buf_count(buf_count),
      .buf_head(buf_head), .pop(pop), .nib_v(nib_v), .nib(nib),
      .token_out(token_out)
   );

   rdo_serializer #(.MSB_FIRST(MSB_FIRST)) u_ser (
      .clk(clk), .clk_fast(clk_fast), .rst_n(rst_n), .nib_v(nib_v),
      .nib(nib), .ser_data(ser_data), .ser_sync(ser_sync)
   );
endmodule

// File: rtl/rdo_chk.sv
module rdo_chk #(
   parameter int NCOL   = 26,
   parameter int LOST_W = 8
) (
   input logic              clk,
   input logic              clk_fast,
   input logic              rst_n,
   input logic [NCOL-1:0]   col_valid,
   input logic [NCOL-1:0]   col_ack,
   input logic              buf_full,
   input logic              token_out,
   input logic [LOST_W-1:0] lost_cnt,
   input logic              ser_sync
);
   assert_ack_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col_ack));

   assert_ack_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (col_ack & ~col_valid) == '0);

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      buf_full |-> (col_ack == '0));

   assert_lost_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (col_ack != '0) |=> $stable(lost_cnt));

   assert_lost_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (&lost_cnt) |=> (&lost_cnt));

   assert_token_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      token_out |=> !token_out);

   assert_sync_single_R8: assert property (@(posedge clk_fast) disable iff (!rst_n)
      ser_sync |=> !ser_sync);
endmodule

bind pix_rdo_top rdo_chk #(.NCOL(NCOL), .LOST_W(LOST_W)) u_chk (
   .clk(clk), .clk_fast(clk_fast), .rst_n(rst_n), .col_valid(col_valid),
   .col_ack(col_ack), .buf_full(buf_full), .token_out(token_out),
   .lost_cnt(lost_cnt), .ser_sync(ser_sync)
);

// File: tb/pix_rdo_top_tb.sv
`timescale 1ns/1ps
module pix_rdo_top_tb;
   localparam int NCOL = 26, ADDR_W = 15, PH_W = 8, REC_W = 23;
   localparam int DEPTH = 8, LOST_W = 4, LOST_MAX = 15;

   logic clk = 1'b0, clk_fast = 1'b0, rst_n = 1'b0;
   logic [NCOL-1:0] col_valid = '0;
   logic [NCOL*REC_W-1:0] col_data = '0;
   logic [NCOL-1:0] col_ack;
   logic token_in = 1'b0, token_out;
   logic [LOST_W-1:0] lost_cnt;
   logic ser_data, ser_sync;

   pix_rdo_top #(.NCOL(NCOL), .ADDR_W(ADDR_W), .PH_W(PH_W), .DEPTH(DEPTH),
                 .LOST_W(LOST_W)) u_dut (
      .clk(clk), .clk_fast(clk_fast), .rst_n(rst_n), .col_valid(col_valid),
      .col_data(col_data), .col_ack(col_ack), .token_in(token_in),
      .token_out(token_out), .lost_cnt(lost_cnt), .ser_data(ser_data),
      .ser_sync(ser_sync)
   );

   int checks = 0, fails = 0;
   bit done = 0;
   logic [3:0] exp_nib[$];
   string exp_tag[$];
   logic [REC_W-1:0] mfifo[$];
   int exp_lost = 0, tok_issued = 0, tok_seen = 0;
   bit busy = 0;
   logic [NCOL-1:0] acked_prev = '0, last_ack = '0;

   // 50 MHz core clock, serializer clock four times faster, rising edges aligned
   initial begin
      int k;
      k = 0;
      forever begin
         #2.5;
         clk_fast = ~clk_fast;
         k++;
         if ((k % 4) == 1) clk = ~clk;
      end
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // deserializer on the falling edge of the fast clock
   int bcnt = 0;
   logic [3:0] acc = '0;
   always @(negedge clk_fast) begin
      if (!rst_n) begin
         bcnt = 0;
      end else begin
         if (ser_sync) begin
            acc = {3'b000, ser_data};
            bcnt = 1;
         end else if (bcnt > 0) begin
            acc = {acc[2:0], ser_data};
            bcnt++;
         end else if (ser_data) begin
            check(1'b0, "R8", "data high outside nibble", 1, 0);
         end
         if (bcnt == 4) begin
            bcnt = 0;
            if (exp_nib.size() == 0) begin
               check(1'b0, "R10", "unexpected nibble", acc, 0);
            end else begin
               logic [3:0] e;
               string t;
               e = exp_nib.pop_front();
               t = exp_tag.pop_front();
               check(acc == e, t, "serial nibble", acc, e);
            end
         end
      end
   end

   task automatic expect_frame(input string tag);
      int snap;
      snap = mfifo.size();
      exp_nib.push_back(4'hA); exp_tag.push_back(tag);
      exp_nib.push_back(4'h6); exp_tag.push_back(tag);
      for (int r = 0; r < snap; r++) begin
         logic [23:0] w;
         w = {1'b0, mfifo.pop_front()};
         for (int n = 5; n >= 0; n--) begin
            exp_nib.push_back(w[n*4 +: 4]);
            exp_tag.push_back(tag);
         end
      end
      if (snap > 0) begin
         exp_nib.push_back(4'h9); exp_tag.push_back(tag);
      end
   endtask

   // one core cycle: check, drive at falling edge, read grants just after
   task automatic cycle(input bit tok, input int pnew, input string tag);
      @(negedge clk);
      if (token_out) begin
         tok_seen++;
         busy = 0;
      end
      check(lost_cnt == LOST_W'(exp_lost), (exp_lost == LOST_MAX) ? "R5" : "R4",
            "lost count", lost_cnt, exp_lost);
      col_valid = col_valid & ~acked_prev;
      for (int i = 0; i < NCOL; i++) begin
         if (!col_valid[i] && pnew > 0 && ($urandom % pnew) == 0) begin
            col_valid[i] = 1'b1;
            col_data[i*REC_W +: REC_W] = REC_W'($urandom);
         end
      end
      token_in = 1'b0;
      if (tok) begin
         token_in = 1'b1;
         if (!busy) begin
            expect_frame(tag);
            busy = 1;
            tok_issued++;
         end
      end
      #1;
      last_ack = col_ack;
      for (int i = 0; i < NCOL; i++)
         if (col_ack[i]) mfifo.push_back(col_data[i*REC_W +: REC_W]);
      if ((|col_valid) && col_ack == '0 && exp_lost < LOST_MAX) exp_lost++;
      acked_prev = col_ack;
   endtask

   task automatic wait_idle(input int pnew, input string tag);
      for (int n = 0; n < 400 && busy; n++) cycle(1'b0, pnew, tag);
      check(!busy, tag, "token passed on", busy, 0);
      repeat (3) cycle(1'b0, pnew, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      col_valid = '0;
      token_in = 1'b0;
      acked_prev = '0;
      repeat (3) @(negedge clk);
      mfifo.delete();
      exp_lost = 0;
      busy = 0;
      rst_n = 1'b1;
   endtask

   initial begin
      #(20.0 * 150000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      do_reset();
      @(negedge clk);
      check(token_out == 1'b0, "R1", "token_out after reset", token_out, 0);
      check(lost_cnt == '0, "R1", "lost_cnt after reset", lost_cnt, 0);
      check(col_ack == '0, "R1", "col_ack after reset", col_ack, 0);
      check(ser_sync == 1'b0 && ser_data == 1'b0, "R1", "serial idle after reset",
            {ser_sync, ser_data}, 0);

      // empty buffer: header only
      cycle(1'b1, 0, "R6");
      wait_idle(0, "R6");
      check(exp_nib.size() == 0, "R6", "header-only frame consumed", exp_nib.size(), 0);
      check(tok_seen == 1, "R6", "token_out pulses", tok_seen, 1);

      // all columns valid: round robin from column 0, then full
      for (int i = 0; i < DEPTH; i++) begin
         cycle(1'b0, 1, "R2");
         check(last_ack == (NCOL'(1) << i), "R2", "grant order", last_ack, NCOL'(1) << i);
      end
      for (int i = 0; i < 20; i++) begin
         cycle(1'b0, 1, "R3");
         check(last_ack == '0, "R3", "no grant while full", last_ack, 0);
      end
      cycle(1'b0, 1, "R5");
      check(lost_cnt == LOST_W'(LOST_MAX), "R5", "lost saturated", lost_cnt, LOST_MAX);

      // full buffer frame, ignored second token, refill continues at column 8
      cycle(1'b1, 1, "R7");
      cycle(1'b1, 1, "R10");
      for (int n = 0; n < 40 && last_ack == '0; n++) cycle(1'b0, 1, "R2");
      check(last_ack == (NCOL'(1) << DEPTH), "R2", "grant resumes after last",
            last_ack, NCOL'(1) << DEPTH);
      wait_idle(1, "R7");
      cycle(1'b1, 0, "R9");
      wait_idle(0, "R9");
      check(exp_nib.size() == 0, "R7", "frames fully received", exp_nib.size(), 0);
      check(tok_seen == tok_issued, "R10", "one token_out per accepted token",
            tok_seen, tok_issued);

      // constrained random phase
      do_reset();
      for (int n = 0; n < 4000; n++) begin
         bit t;
         t = ($urandom % 12) == 0;
         cycle(t, 16, busy ? "R10" : "R7");
      end
      for (int n = 0; n < 3000 && (busy || mfifo.size() > 0 || |col_valid); n++)
         cycle(!busy, 0, "R9");
      wait_idle(0, "R9");
      check(exp_nib.size() == 0, "R7", "random frames fully received", exp_nib.size(), 0);
      check(mfifo.size() == 0, "R9", "all records sent", mfifo.size(), 0);
      check(tok_seen == tok_issued, "R6", "token_out count", tok_seen, tok_issued);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule